// File: doc/BRIEF.md
# Associative Power-of-Two Segment Translator

This block translates virtual addresses to physical addresses. It keeps a small pool of segment descriptors and checks every one of them in parallel on each access. Each descriptor covers one region of 2^k bytes. The region starts on a multiple of its own size, in virtual space and in physical space alike, and k is chosen per descriptor. A descriptor also carries a write-protect bit and an address-space tag. Because of the tag, descriptors for several address spaces can be loaded at the same time, and a context switch only changes the `cur_asid` input.

Software writes descriptors one at a time through a load port. A load that breaks the alignment rule is refused, and the port raises an error flag. An access presents an address, a read/write flag and the current address-space number. After a fixed two-cycle delay the block returns one of three results: a physical address, a miss fault or a protection fault. When several descriptors match, the one with the lowest index is used.

Top module: `seg_xlat`

## Requirements
- R1: After synchronous reset, all descriptors are invalid, all response outputs are 0 and `ld_err` is 0. An access made right after reset therefore reports a miss.
- R2: A descriptor matches an access only when all three of these hold: it is valid, its address-space tag equals `cur_asid`, and the virtual-address bits at positions k and above equal the same bits of its virtual base.
- R3: On a hit without a fault, `rsp_pa` is built from two parts. Bits at positions k and above come from the descriptor's physical base. Bits below k come from the access's virtual address.
- R4: When several descriptors match, the lowest-numbered one is used, and `rsp_idx` reports its number.
- R5: When no descriptor matches, `rsp_miss` is 1, `rsp_prot` is 0, and `rsp_pa` and `rsp_idx` are 0.
- R6: A write (`acc_wr`=1) that hits a descriptor with write-protect set gives `rsp_prot`=1 and `rsp_pa`=0. A read of the same descriptor translates normally with no fault.
- R7: A load with `ld_valid`=1 is refused in either of these cases: `ld_k` exceeds VA_W, or the virtual or physical base has a nonzero bit below position `ld_k`. A refused load leaves the slot unchanged. A load with `ld_valid`=0 always succeeds and invalidates the slot. From the edge of each load, `ld_err` shows whether that load was refused, and it holds that value until the next load.
- R8: An access sampled at clock edge N produces `rsp_valid`=1 after edge N+2, for exactly one cycle per access. When `rsp_valid` is 0, the other response outputs are 0. An access uses only descriptor contents written at edges before the edge that samples it.
- R9: Descriptors with different address-space tags can be resident together. Changing `cur_asid` selects between them without any reload.
- R10: With k equal to VA_W, a descriptor covers the whole virtual space. With k equal to 0, it covers exactly one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Descriptor load strobe |
| ld_idx | input | IDX_W | Slot to load |
| ld_valid | input | 1 | 1 writes a descriptor, 0 invalidates the slot |
| ld_vbase | input | VA_W | Virtual base of the region |
| ld_pbase | input | PA_W | Physical base of the region |
| ld_k | input | K_W | Size exponent; the region is 2^k bytes |
| ld_asid | input | ASID_W | Address-space tag |
| ld_wp | input | 1 | Write-protect |
| ld_err | output | 1 | The last load was refused |
| cur_asid | input | ASID_W | Current address-space number |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | Access is a write |
| acc_va | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Response is present |
| rsp_miss | output | 1 | No descriptor matched |
| rsp_prot | output | 1 | Write to a write-protected region |
| rsp_pa | output | PA_W | Physical address |
| rsp_idx | output | IDX_W | Number of the descriptor used |

## Verification
The bench builds the block with eight slots, a 16-bit virtual address, a 20-bit physical address and a 3-bit tag. With only eight slots, random regions overlap often, so multiple matches and lowest-index priority occur frequently. Because PA_W is wider than VA_W, the checks show that physical bits above the virtual width come from the base. With a 16-bit virtual space, both extremes are reachable: whole-space regions (k=16) and the out-of-range exponent 17. Random loads are interleaved with accesses, including loads in the same cycle as an access, to exercise the ordering between descriptor updates and lookups.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;
endpackage

// File: rtl/seg_slot.sv
module seg_slot #(
  parameter int VA_W   = 24,
  parameter int PA_W   = 24,
  parameter int ASID_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [VA_W-1:0]   wr_vbase,
  input  logic [PA_W-1:0]   wr_pbase,
  input  logic [PA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_wp,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VA_W-1:0]   va,
  output logic              hit,
  output logic [PA_W-1:0]   pa,
  output logic              wp
);
  logic              valid_q;
  logic [VA_W-1:0]   vbase_q;
  logic [PA_W-1:0]   pbase_q;
  logic [PA_W-1:0]   mask_q;
  logic [ASID_W-1:0] asid_q;
  logic              wp_q;
  logic [VA_W-1:0]   vmask;
  logic [PA_W-1:0]   va_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vbase_q <= '0;
      pbase_q <= '0;
      mask_q  <= '0;
      asid_q  <= '0;
      wp_q    <= 1'b0;
    end else if (wr_en) begin
      valid_q <= wr_valid;
      vbase_q <= wr_vbase;
      pbase_q <= wr_pbase;
      mask_q  <= wr_mask;
      asid_q  <= wr_asid;
      wp_q    <= wr_wp;
    end
  end

  assign vmask = mask_q[VA_W-1:0];
  assign va_x  = PA_W'(va);
  assign hit   = valid_q && (asid_q == cur_asid) && (((va ^ vbase_q) & ~vmask) == '0);
  assign pa    = (pbase_q & ~mask_q) | (va_x & mask_q);
  assign wp    = wp_q;

  // R7: a resident descriptor is always aligned to its own size
  p_stored_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (((vbase_q & vmask) == '0) && ((pbase_q & mask_q) == '0)));
endmodule

// File: rtl/seg_pick.sv
module seg_pick #(
  parameter int N    = 32,
  parameter int IW   = 5
) (
  input  logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat #(
  parameter int NUM_SEG = 32,
  parameter int VA_W    = 24,
  parameter int PA_W    = 24,
  parameter int ASID_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SEG),
  localparam int K_W    = $clog2(VA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_valid,
  input  logic [VA_W-1:0]   ld_vbase,
  input  logic [PA_W-1:0]   ld_pbase,
  input  logic [K_W-1:0]    ld_k,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic              ld_wp,
  output logic              ld_err,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [VA_W-1:0]   acc_va,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic              rsp_prot,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [IDX_W-1:0]  rsp_idx
);
  import seg_pkg::*;

  // load-side checks: the size mask is built once here and shared by all slots
  logic [PA_W:0]   k_one;
  logic [PA_W-1:0] ld_mask;
  logic            k_bad, align_bad, ld_ok;

  assign k_one     = (PA_W + 1)'(1) << ld_k;
  assign ld_mask   = k_one[PA_W-1:0] - PA_W'(1);
  assign k_bad     = ld_k > K_W'(VA_W);
  assign align_bad = ((PA_W'(ld_vbase) | ld_pbase) & ld_mask) != '0;
  assign ld_ok     = !ld_valid || (!k_bad && !align_bad);

  always_ff @(posedge clk) begin
    if (rst)        ld_err <= 1'b0;
    else if (ld_en) ld_err <= !ld_ok;
  end

  // R7: the error flag only moves on a load
  p_lderr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(ld_err));

  // descriptor pool
  logic [NUM_SEG-1:0] hit_vec;
  logic [NUM_SEG-1:0] wp_vec;
  logic [PA_W-1:0]    pa_arr [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    seg_slot #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (ld_en && ld_ok && (ld_idx == IDX_W'(g))),
      .wr_valid (ld_valid),
      .wr_vbase (ld_vbase),
      .wr_pbase (ld_pbase),
      .wr_mask  (ld_mask),
      .wr_asid  (ld_asid),
      .wr_wp    (ld_wp),
      .cur_asid (cur_asid),
      .va       (acc_va),
      .hit      (hit_vec[g]),
      .pa       (pa_arr[g]),
      .wp       (wp_vec[g])
    );
  end

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  seg_pick #(.N(NUM_SEG), .IW(IDX_W)) u_pick (
    .hit (hit_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  // R4: the chosen slot is a hit and no lower slot hits
  p_pick_lowest_r4: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> (hit_vec[pick_idx] &&
                  ((hit_vec & ((NUM_SEG)'(1) << pick_idx) - (NUM_SEG)'(1)) == '0)));

  // stage 1: match, select and fault decision
  logic             s1_valid;
  fault_e           s1_flt;
  logic [PA_W-1:0]  s1_pa;
  logic [IDX_W-1:0] s1_idx;
  logic             sel_wp;
  logic [PA_W-1:0]  sel_pa;

  assign sel_wp = wp_vec[pick_idx];
  assign sel_pa = pa_arr[pick_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_flt   <= FLT_NONE;
      s1_pa    <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= acc_en;
      s1_flt   <= FLT_NONE;
      s1_pa    <= '0;
      s1_idx   <= '0;
      if (acc_en) begin
        if (!pick_any) begin
          s1_flt <= FLT_MISS;
        end else begin
          s1_idx <= pick_idx;
          if (acc_wr && sel_wp) s1_flt <= FLT_PROT;
          else                  s1_pa  <= sel_pa;
        end
      end
    end
  end

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_pa    <= '0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_miss  <= s1_flt == FLT_MISS;
      rsp_prot  <= s1_flt == FLT_PROT;
      rsp_pa    <= s1_pa;
      rsp_idx   <= s1_idx;
    end
  end

  // R8: fixed two-cycle response
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> ##1 rsp_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> ##1 !rsp_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_miss && !rsp_prot && rsp_pa == '0 && rsp_idx == '0));
  // R5 / R6: fault outputs are exclusive and clear the address
  p_fault_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rsp_miss && rsp_prot));
  p_miss_clean_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_pa == '0 && rsp_idx == '0));
endmodule

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;
  localparam int NS = 8;
  localparam int VW = 16;
  localparam int PW = 20;
  localparam int AW = 3;
  localparam int IW = 3;
  localparam int KW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          ld_en = 0, ld_valid = 0, ld_wp = 0;
  logic [IW-1:0] ld_idx = 0;
  logic [VW-1:0] ld_vbase = 0;
  logic [PW-1:0] ld_pbase = 0;
  logic [KW-1:0] ld_k = 0;
  logic [AW-1:0] ld_asid = 0, cur_asid = 0;
  logic          acc_en = 0, acc_wr = 0;
  logic [VW-1:0] acc_va = 0;
  logic          ld_err, rsp_valid, rsp_miss, rsp_prot;
  logic [PW-1:0] rsp_pa;
  logic [IW-1:0] rsp_idx;

  seg_xlat #(.NUM_SEG(NS), .VA_W(VW), .PA_W(PW), .ASID_W(AW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_valid(ld_valid),
    .ld_vbase(ld_vbase), .ld_pbase(ld_pbase), .ld_k(ld_k), .ld_asid(ld_asid),
    .ld_wp(ld_wp), .ld_err(ld_err), .cur_asid(cur_asid), .acc_en(acc_en),
    .acc_wr(acc_wr), .acc_va(acc_va), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_prot(rsp_prot), .rsp_pa(rsp_pa), .rsp_idx(rsp_idx));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit     m_v [NS];
  int     m_asid [NS], m_k [NS], m_wp [NS];
  longint m_vb [NS], m_pb [NS];
  bit     m_err;
  longint q_val [$], q_miss [$], q_prot [$], q_pa [$], q_idx [$];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) m_v[i] <= 0;
      m_err <= 0;
      q_val = {0, 0}; q_miss = {0, 0}; q_prot = {0, 0}; q_pa = {0, 0}; q_idx = {0, 0};
    end else begin
      automatic longint e_v = 0, e_m = 0, e_p = 0, e_pa = 0, e_i = 0;
      if (acc_en) begin
        automatic int w = -1;
        for (int i = 0; i < NS; i++) begin
          automatic longint sz = longint'(1) << m_k[i];
          if (w < 0 && m_v[i] && m_asid[i] == cur_asid && (acc_va / sz) == (m_vb[i] / sz)) w = i;
        end
        e_v = 1;
        if (w < 0) e_m = 1;
        else begin
          e_i = w;
          if (acc_wr && m_wp[w] != 0) e_p = 1;
          else e_pa = m_pb[w] + (acc_va % (longint'(1) << m_k[w]));
        end
      end
      q_val.push_back(e_v); q_miss.push_back(e_m); q_prot.push_back(e_p);
      q_pa.push_back(e_pa); q_idx.push_back(e_i);
      void'(q_val.pop_front()); void'(q_miss.pop_front()); void'(q_prot.pop_front());
      void'(q_pa.pop_front()); void'(q_idx.pop_front());
      if (ld_en) begin
        automatic bit ok;
        automatic longint sz = longint'(1) << ld_k;
        ok = !ld_valid || (ld_k <= VW && (ld_vbase % sz) == 0 && (ld_pbase % sz) == 0);
        m_err <= !ok;
        if (ok) begin
          m_v[ld_idx] <= ld_valid; m_asid[ld_idx] <= ld_asid; m_k[ld_idx] <= ld_k;
          m_wp[ld_idx] <= ld_wp; m_vb[ld_idx] <= ld_vbase; m_pb[ld_idx] <= ld_pbase;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (q_val.size() == 2) begin
      check("R8 rsp_valid", rsp_valid, q_val[0]);
      check("R5 rsp_miss", rsp_miss, q_miss[0]);
      check("R6 rsp_prot", rsp_prot, q_prot[0]);
      check("R3 rsp_pa", rsp_pa, q_pa[0]);
      check("R4 rsp_idx", rsp_idx, q_idx[0]);
      check("R7 ld_err", ld_err, m_err);
    end
  end

  task automatic load(int idx, bit v, longint vb, longint pb, int k, int asid, bit wp);
    @(negedge clk);
    ld_en = 1; ld_idx = IW'(idx); ld_valid = v; ld_vbase = VW'(vb); ld_pbase = PW'(pb);
    ld_k = KW'(k); ld_asid = AW'(asid); ld_wp = wp;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic probe(string tag, int asid, bit wr, longint va,
                       bit e_miss, bit e_prot, longint e_pa, int e_idx);
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_va = VW'(va); cur_asid = AW'(asid);
    @(negedge clk);
    acc_en = 0;
    @(negedge clk);
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " miss"}, rsp_miss, e_miss);
    check({tag, " prot"}, rsp_prot, e_prot);
    check({tag, " pa"}, rsp_pa, e_pa);
    check({tag, " idx"}, rsp_idx, e_idx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 rsp_pa", rsp_pa, 0);
    check("R1 ld_err", ld_err, 0);
    rst = 0;
    probe("R1 empty pool", 0, 0, 16'h0000, 1, 0, 0, 0);

    load(0, 1, 16'h1000, 20'h23000, 12, 1, 0);
    probe("R2 hit", 1, 0, 16'h1abc, 0, 0, 20'h23abc, 0);
    probe("R2 other tag", 2, 0, 16'h1abc, 1, 0, 0, 0);
    probe("R2 outside", 1, 0, 16'h2abc, 1, 0, 0, 0);
    load(1, 1, 16'h1000, 20'h40000, 8, 2, 0);
    probe("R9 tag two", 2, 0, 16'h10ff, 0, 0, 20'h400ff, 1);
    probe("R9 back to one", 1, 0, 16'h10ff, 0, 0, 20'h230ff, 0);
    load(3, 1, 16'h1a00, 20'h50000, 8, 1, 0);
    probe("R4 lowest wins", 1, 0, 16'h1abc, 0, 0, 20'h23abc, 0);
    load(2, 1, 16'h8000, 20'h00070, 4, 1, 1);
    probe("R6 write protected", 1, 1, 16'h8005, 0, 1, 0, 2);
    probe("R6 read allowed", 1, 0, 16'h8005, 0, 0, 20'h00075, 2);
    load(5, 1, 16'h1010, 20'h60000, 8, 3, 0);
    check("R7 misaligned flag", ld_err, 1);
    probe("R7 slot unchanged", 3, 0, 16'h1010, 1, 0, 0, 0);
    load(5, 1, 16'h1000, 20'h60010, 8, 3, 0);
    check("R7 physical misaligned", ld_err, 1);
    load(5, 1, 16'h0000, 20'h00000, 17, 3, 0);
    check("R7 exponent too large", ld_err, 1);
    load(6, 1, 16'h0000, 20'h30000, 16, 4, 0);
    check("R7 accepted clears flag", ld_err, 0);
    probe("R10 whole space", 4, 0, 16'hffff, 0, 0, 20'h3ffff, 6);
    load(7, 1, 16'h1234, 20'h05678, 0, 5, 0);
    probe("R10 single byte", 5, 0, 16'h1234, 0, 0, 20'h05678, 7);
    probe("R10 neighbour misses", 5, 0, 16'h1235, 1, 0, 0, 0);
    load(0, 0, 0, 0, 0, 0, 0);
    probe("R4 after invalidate", 1, 0, 16'h1abc, 0, 0, 20'h500bc, 3);

    // mixed random traffic, loads and accesses may share a cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      acc_en = ($urandom % 4) != 0;
      acc_wr = $urandom % 2;
      cur_asid = AW'($urandom % 3);
      acc_va = VW'($urandom);
      ld_en = ($urandom % 5) == 0;
      if (ld_en) begin
        automatic int k = $urandom % 18;
        automatic longint sz = longint'(1) << k;
        automatic longint vb = $urandom % 65536;
        automatic longint pb = $urandom % 1048576;
        if ($urandom % 5 != 0) begin vb = vb - (vb % sz); pb = pb - (pb % sz); end
        ld_idx = IW'($urandom); ld_valid = ($urandom % 6) != 0; ld_k = KW'(k);
        ld_vbase = VW'(vb); ld_pbase = PW'(pb); ld_asid = AW'($urandom % 3);
        ld_wp = $urandom % 2;
      end
    end
    @(negedge clk);
    acc_en = 0; ld_en = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule